// File: doc/BRIEF.md
# Parallel Frame Scrambler

This block whitens transmit data with a pseudo-random bit sequence from a 7-bit linear feedback register whose output repeats every 127 bits. Instead of producing one sequence bit per clock, the feedback register is unrolled so that 24 consecutive sequence bits come out together. A whole 24-bit data frame is scrambled in a single cycle, and the register jumps ahead by 24 steps when that frame is accepted.

A message starts with a one-cycle seed load. After that, frames are presented on a valid/ready input. The scrambled frame comes out combinationally in the same cycle. Its valid flag follows the input valid, and the input ready flag follows the downstream ready. Because no full-period table is stored, back-to-back short messages each cost only one extra cycle.

The output is bit-exact with a bit-serial scrambler that consumes frame bit 0 first.

Top module: `frame_scrambler`

## Requirements
- R1: After synchronous active-low reset, the generator state is all ones (7'b1111111). The first accepted frame is therefore scrambled as if that value had been loaded as the seed.
- R2: Output bit k equals input bit k XOR sequence bit k. Bit 0 is the earliest bit in time and uses the first sequence bit after the current state. Each sequence bit is state bit 7 XOR state bit 4 (polynomial x^7 + x^4 + 1), and that bit is shifted into state bit 1 while the other state bits move up one position.
- R3: The scrambled frame and its valid flag appear in the same cycle as the input frame. There is no register stage between `in_data` and `out_data`.
- R4: When a frame is accepted (`in_valid` and `in_ready` both high), the state moves forward by exactly 24 sequence steps. The sequence continues without a gap into the next frame.
- R5: In a cycle with no accepted frame and no seed load, the state holds. A later frame continues the sequence as if the idle cycle had not happened.
- R6: A cycle with `seed_load` high loads `seed_in` as the new state, holds `in_ready` and `out_valid` low, and accepts no frame. The next accepted frame starts the sequence from the loaded seed.
- R7: A seed of all zeros is replaced by all ones, so a zero seed gives the same output as seed 7'b1111111.
- R8: With constant input data, the output frames repeat with a period of exactly 127 accepted frames.
- R9: Outside a seed-load cycle, `in_ready` equals `out_ready` and `out_valid` equals `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| seed_load | input | 1 | Load `seed_in` as the generator state this cycle |
| seed_in | input | 7 | Seed for the new message; bit 6 is state bit 7 |
| in_valid | input | 1 | Input frame present |
| in_ready | output | 1 | Frame is taken this cycle |
| in_data | input | 24 | Plain frame; bit 0 is earliest |
| out_valid | output | 1 | Scrambled frame present |
| out_ready | input | 1 | Downstream can take a frame |
| out_data | output | 24 | Scrambled frame |

## Verification
Two situations are hard to reach from the ports, and the bench drives each one deliberately.

The first is a seed load that lands in the same cycle as a presented frame. The stimulus holds `in_valid` high through the load cycle and then checks that the next frame starts from the new seed, with no trace of the rejected frame.

The second is the full-period wrap, which only shows after 127 accepted frames. The bench streams 128 constant frames from one seed and compares the last against the first. It also sends a zero seed and compares the result with the output recorded earlier for the all-ones state.

Every cycle is also checked against a serial model. The model keeps a queue of past sequence bits and computes each new bit from the bits seven and four places back.

// File: rtl/scr_pkg.sv
// Package: shared defaults and the generator state type for the frame
// scrambler. Assumes the state fits in a few bits and taps lie within it.
package scr_pkg;
    parameter int unsigned DEF_LFSR_W  = 7;
    parameter int unsigned DEF_TAP_HI  = 7;
    parameter int unsigned DEF_TAP_LO  = 4;
    parameter int unsigned DEF_FRAME_W = 24;

    typedef logic [DEF_LFSR_W-1:0] lfsr_state_t;
endpackage

// File: rtl/scr_seed_guard.sv
// Module: scr_seed_guard
// Cleans a seed before it reaches the generator. An all-zero seed would lock
// the feedback register at zero forever, so it is replaced by all ones.
// Assumes: purely combinational, with no state of its own.
module scr_seed_guard #(
    parameter int unsigned LFSR_W = scr_pkg::DEF_LFSR_W
) (
    input  logic [LFSR_W-1:0] raw_seed,
    output logic [LFSR_W-1:0] safe_seed
);
    // Purpose: substitute all ones when the raw seed is zero.
    always_comb begin
        if (raw_seed == '0) begin
            safe_seed = '1;
        end else begin
            safe_seed = raw_seed;
        end
    end
endmodule

// File: rtl/scr_unroll.sv
// Module: scr_unroll
// Unrolled feedback register. From the current state it produces FRAME_W
// consecutive sequence bits (bit 0 first in time) and the state reached
// after that many steps. Each step XORs taps TAP_HI and TAP_LO (1-based)
// and shifts the result into the lowest state bit.
// Assumes: TAP_HI equals LFSR_W, TAP_LO is below TAP_HI, and the logic
// depth of FRAME_W chained XORs fits the clock period.
module scr_unroll #(
    parameter int unsigned LFSR_W  = scr_pkg::DEF_LFSR_W,
    parameter int unsigned TAP_HI  = scr_pkg::DEF_TAP_HI,
    parameter int unsigned TAP_LO  = scr_pkg::DEF_TAP_LO,
    parameter int unsigned FRAME_W = scr_pkg::DEF_FRAME_W
) (
    input  logic [LFSR_W-1:0]  cur_state,
    output logic [FRAME_W-1:0] seq_bits,
    output logic [LFSR_W-1:0]  adv_state
);
    localparam int unsigned HI_IDX = TAP_HI - 1;
    localparam int unsigned LO_IDX = TAP_LO - 1;

    // Stage k holds the state after k serial steps.
    logic [LFSR_W-1:0] stage [FRAME_W+1];

    assign stage[0] = cur_state;

    genvar k;
    generate
        for (k = 0; k < FRAME_W; k++) begin : g_step
            // Purpose: one serial step, making one sequence bit and the next state.
            assign seq_bits[k]  = stage[k][HI_IDX] ^ stage[k][LO_IDX];
            assign stage[k+1]   = {stage[k][LFSR_W-2:0], seq_bits[k]};
        end
    endgenerate

    assign adv_state = stage[FRAME_W];
endmodule

// File: rtl/scr_state_reg.sv
// Module: scr_state_reg
// Holds the generator state. It resets to all ones, loads a cleaned seed
// on request, moves to the advanced state when a frame is accepted, and
// holds otherwise. A seed load takes priority over frame acceptance.
// Assumes: synchronous active-low reset.
module scr_state_reg #(
    parameter int unsigned LFSR_W = scr_pkg::DEF_LFSR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [LFSR_W-1:0] load_val,
    input  logic              adv_en,
    input  logic [LFSR_W-1:0] adv_val,
    output logic [LFSR_W-1:0] state_q
);
    // Purpose: choose between reset, seed load, advance and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '1;
        end else if (load_en) begin
            state_q <= load_val;
        end else if (adv_en) begin
            state_q <= adv_val;
        end
    end
endmodule

// File: rtl/frame_scrambler.sv
// Module: frame_scrambler (top)
// Scrambles one FRAME_W-bit frame per clock with an x^7+x^4+1 sequence.
// The frame passes straight through, combinationally, with the unrolled
// sequence XORed in. The state register jumps FRAME_W steps per accepted
// frame. A seed-load cycle stalls the handshake for that one cycle.
// Assumes: the downstream stage registers out_data, and in_data is held
// stable while in_valid is high.
module frame_scrambler #(
    parameter int unsigned LFSR_W  = scr_pkg::DEF_LFSR_W,
    parameter int unsigned TAP_HI  = scr_pkg::DEF_TAP_HI,
    parameter int unsigned TAP_LO  = scr_pkg::DEF_TAP_LO,
    parameter int unsigned FRAME_W = scr_pkg::DEF_FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               seed_load,
    input  logic [LFSR_W-1:0]  seed_in,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [FRAME_W-1:0] in_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [FRAME_W-1:0] out_data
);
    logic [LFSR_W-1:0]  state_q;
    logic [LFSR_W-1:0]  state_adv;
    logic [LFSR_W-1:0]  seed_clean;
    logic [FRAME_W-1:0] seq_bits;
    logic               frame_take;

    // Purpose: handshake; a seed-load cycle blocks both directions.
    always_comb begin
        in_ready   = out_ready & ~seed_load;
        out_valid  = in_valid & ~seed_load;
        frame_take = in_valid & in_ready;
    end

    // Purpose: scramble the frame with this cycle's sequence bits.
    always_comb begin
        out_data = in_data ^ seq_bits;
    end

    scr_seed_guard #(
        .LFSR_W (LFSR_W)
    ) u_guard (
        .raw_seed  (seed_in),
        .safe_seed (seed_clean)
    );

    scr_unroll #(
        .LFSR_W  (LFSR_W),
        .TAP_HI  (TAP_HI),
        .TAP_LO  (TAP_LO),
        .FRAME_W (FRAME_W)
    ) u_unroll (
        .cur_state (state_q),
        .seq_bits  (seq_bits),
        .adv_state (state_adv)
    );

    scr_state_reg #(
        .LFSR_W (LFSR_W)
    ) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (seed_load),
        .load_val (seed_clean),
        .adv_en   (frame_take),
        .adv_val  (state_adv),
        .state_q  (state_q)
    );
endmodule

// File: rtl/frame_scrambler_sva.sv
// Checker for frame_scrambler, bound to every instance of the top module.
// Relates the handshake, the datapath and the state register over time.
module frame_scrambler_sva #(
    parameter int unsigned LFSR_W  = scr_pkg::DEF_LFSR_W,
    parameter int unsigned FRAME_W = scr_pkg::DEF_FRAME_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               seed_load,
    input logic               in_valid,
    input logic               in_ready,
    input logic [FRAME_W-1:0] in_data,
    input logic               out_valid,
    input logic               out_ready,
    input logic [FRAME_W-1:0] out_data,
    input logic [FRAME_W-1:0] seq_bits,
    input logic [LFSR_W-1:0]  state_q
);
    // R2: the output differs from the input exactly by the generated sequence.
    p_xor_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data ^ in_data) == seq_bits));

    // R4: an accepted frame always moves the state (24 is not a multiple of 127).
    p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !seed_load) |=> (state_q != $past(state_q)));

    // R5: with no accepted frame and no load, the state holds.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_load && !(in_valid && in_ready)) |=> $stable(state_q));

    // R6: a load cycle takes no frame and offers no output.
    p_load_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |-> (!in_ready && !out_valid));

    // R7: the state never becomes all zeros.
    p_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    // R9: outside a load, ready and valid pass straight through.
    p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !seed_load |-> ((in_ready == out_ready) && (out_valid == in_valid)));
endmodule

bind frame_scrambler frame_scrambler_sva #(
    .LFSR_W  (LFSR_W),
    .FRAME_W (FRAME_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed_load (seed_load),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .seq_bits  (seq_bits),
    .state_q   (state_q)
);

// File: tb/frame_scrambler_tb.sv
`timescale 1ns/1ps
module frame_scrambler_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_load = 1'b0;
    logic [6:0]  seed_in = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [23:0] out_data;

    int compared = 0;
    int mismatched = 0;

    // Serial reference: hist[0] is the bit 7 steps back, hist[6] the newest.
    bit hist[$];

    logic [23:0] ones_first;
    logic [23:0] period_first;

    always #10 clk = ~clk;

    frame_scrambler u_dut (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_in(seed_in),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic void model_seed(input logic [6:0] s);
        logic [6:0] v;
        v = (s == 7'd0) ? 7'h7F : s;
        hist.delete();
        for (int i = 6; i >= 0; i--) hist.push_back(v[i]);
    endfunction

    function automatic logic [23:0] model_peek();
        bit tmp[$];
        logic [23:0] r;
        tmp = hist;
        for (int n = 0; n < 24; n++) begin
            bit b;
            b = tmp[0] ^ tmp[3];
            r[n] = b;
            void'(tmp.pop_front());
            tmp.push_back(b);
        end
        return r;
    endfunction

    function automatic void model_advance();
        for (int n = 0; n < 24; n++) begin
            bit b;
            b = hist[0] ^ hist[3];
            void'(hist.pop_front());
            hist.push_back(b);
        end
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check the outputs in that same
    // cycle (R3), then update the model for the coming rising edge.
    task automatic cyc(input bit v, input logic [23:0] d, input bit ordy,
                       input bit ld, input logic [6:0] sd, input string tag);
        logic [23:0] exp_d;
        @(negedge clk);
        in_valid = v; in_data = d; out_ready = ordy; seed_load = ld; seed_in = sd;
        #2;
        check(in_ready == (ordy && !ld), {tag, "/R9 ready"}, in_ready, ordy && !ld);
        check(out_valid == (v && !ld), {tag, "/R3 valid"}, out_valid, v && !ld);
        if (rst_n && v && !ld) begin
            exp_d = d ^ model_peek();
            check(out_data == exp_d, {tag, "/R2 data"}, out_data, exp_d);
        end
        if (!rst_n) model_seed(7'h7F);
        else if (ld) model_seed(sd);
        else if (v && ordy) model_advance();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        model_seed(7'h7F);
        // R1 / R9: during reset, the handshake still follows out_ready.
        for (int i = 0; i < 3; i++) cyc(1'b0, 24'h0, i[0], 1'b0, 7'h0, "R9 reset");
        @(negedge clk); rst_n = 1'b1;
        // R1: the first frame after reset uses the all-ones state.
        cyc(1'b1, 24'h0, 1'b1, 1'b0, 7'h0, "R1 first frame");
        #1;
        ones_first = 24'h0;
        begin
            logic [23:0] e;
            model_seed(7'h7F);
            e = model_peek();
            model_advance();
            ones_first = e;
            // Hand-derived prefix of the all-ones sequence: 0,0,0,0,1,1,1,0 (bit 0 first).
            check(e[7:0] == 8'h70, "R1 sequence prefix", e[7:0], 8'h70);
        end
        // R2, R4: back-to-back random frames.
        for (int i = 0; i < 40; i++) cyc(1'b1, 24'($urandom), 1'b1, 1'b0, 7'h0, "R4 stream");
        // R5: valid gaps and downstream stalls.
        for (int i = 0; i < 30; i++)
            cyc(i % 3 != 0, 24'($urandom), i % 4 != 1, 1'b0, 7'h0, "R5 gaps");
        // R6: a load while a frame is presented, then continue.
        cyc(1'b1, 24'hABCDEF, 1'b1, 1'b1, 7'h35, "R6 load busy");
        for (int i = 0; i < 5; i++) cyc(1'b1, 24'($urandom), 1'b1, 1'b0, 7'h0, "R6 after load");
        cyc(1'b0, 24'h0, 1'b1, 1'b1, 7'h01, "R6 load idle");
        cyc(1'b1, 24'h123456, 1'b1, 1'b0, 7'h0, "R6 after load2");
        // R7: a zero seed behaves as all ones.
        cyc(1'b0, 24'h0, 1'b1, 1'b1, 7'h00, "R7 zero seed");
        cyc(1'b1, 24'h0, 1'b1, 1'b0, 7'h0, "R7 frame");
        check(out_data == ones_first, "R7 zero seed matches ones", out_data, ones_first);
        // R8: 127-frame period with constant data.
        cyc(1'b0, 24'h0, 1'b1, 1'b1, 7'h5A, "R8 load");
        cyc(1'b1, 24'h0F0F0F, 1'b1, 1'b0, 7'h0, "R8 frame0");
        period_first = out_data;
        for (int i = 1; i < 127; i++) begin
            cyc(1'b1, 24'h0F0F0F, 1'b1, 1'b0, 7'h0, "R8 stream");
            check(out_data != period_first || i == 0, "R8 no early repeat", out_data, period_first);
        end
        cyc(1'b1, 24'h0F0F0F, 1'b1, 1'b0, 7'h0, "R8 frame127");
        check(out_data == period_first, "R8 period 127", out_data, period_first);
        @(negedge clk);
        in_valid = 1'b0; seed_load = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule